// File: doc/BRIEF.md
# Configurable LUT Logic Cell

This block is a single programmable logic cell. Three raw input signals, each of which can be masked off, form a 3-bit index into an 8-bit truth table held in configuration. The selected truth-table bit is the cell's logic value. That value can be used directly and combinationally, or passed through a clocked conditioning stage.

The conditioning stage has three settings. It can bypass the value. It can synchronize it through two flip-flops. It can also filter it: the value first goes through the synchronizer, and a two-deep history must then agree with the synchronized value before the output may change. A rising-edge detector can follow the conditioning stage and turn a level into a pulse one cell clock long. The edge detector is only valid when the value is synchronized or filtered. Asking for it with the bypass setting is a configuration error, and the cell then drives its output low.

The cell is meant to be replicated in a fabric of small programmable logic. Input source selection, event routing and pin drivers sit outside it.

Top module: `lut_cell`

## Requirements
- R1: With stage mode 00 and the edge detector off, `cell_out` equals `truth_tbl[idx]`, where idx bit 0 is input 0, idx bit 1 is input 1 and idx bit 2 is input 2.
- R2: An input whose `in_en` bit is 0 contributes 0 to the index, whatever level its raw input has.
- R3: In stage mode 00, `cell_out` follows input and truth-table changes in the same cycle, with no clock edge between them.
- R4: In stage mode 01 (synchronize), `cell_out` is the LUT value sampled two clock edges earlier, so a change appears after exactly two edges.
- R5: In stage mode 10 (filter), a stable change reaches `cell_out` after exactly four edges. The output changes only when the value two stages behind the synchronizer equals the synchronized value, so a LUT pulse lasting one or two cycles is rejected.
- R6: Stage mode 11 is reserved and behaves exactly like mode 00.
- R7: With `edge_en` = 1 and stage mode 01 or 10, `cell_out` gives a pulse one clock long on each rising edge of the conditioned value, and stays low on falling edges and at steady levels.
- R8: With `edge_en` = 1 and stage mode 00 or 11, `cell_out` is held at 0.
- R9: A synchronous `rst` clears every pipeline flip-flop, so after reset the synchronized and filtered outputs read 0 until new values have travelled through the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst | input | 1 | Synchronous reset, active high |
| in_raw | input | 3 | Raw logic inputs; bit i is input i |
| in_en | input | 3 | Per-input enable; 0 forces that index bit to 0 |
| truth_tbl | input | 8 | Truth table; bit n is the output for index n |
| stage_mode | input | 2 | 00 bypass, 01 synchronize, 10 filter, 11 reserved (bypass) |
| edge_en | input | 1 | Enables the rising-edge pulse detector |
| cell_out | output | 1 | Cell result |

## Verification
The bench measures the latency of a clean step in the synchronize and filter settings. A design with one stage too many or too few would give an edge count other than two or four. It sends LUT pulses of one and two cycles into the filter, which a design comparing the wrong history stage would let through. It counts how long an edge pulse stays high, and it enables the edge detector with the bypass and reserved settings: a pulse that stretches or a leaked level shows up at once. Masked inputs are toggled while the truth table depends on them, and long random runs in every mode are compared against a bench model of the pipeline history.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

  typedef enum logic [1:0] {
    STG_BYPASS = 2'b00,
    STG_SYNC   = 2'b01,
    STG_FILTER = 2'b10,
    STG_RSVD   = 2'b11
  } stage_mode_e;

  // True when the selected mode puts at least one clocked stage in the path
  function automatic logic mode_is_clocked(input logic [1:0] mode);
    return (mode == STG_SYNC) || (mode == STG_FILTER);
  endfunction

endpackage

// File: rtl/lut_cell_lut.sv
module lut_cell_lut #(
  parameter int INPUTS = 3,
  localparam int TT_W = 1 << INPUTS
) (
  input  logic [INPUTS-1:0] raw_i,
  input  logic [INPUTS-1:0] en_i,
  input  logic [TT_W-1:0]   tt_i,
  output logic [INPUTS-1:0] idx_o,
  output logic              lut_o
);

  function automatic logic table_pick(input logic [TT_W-1:0] tt,
                                      input logic [INPUTS-1:0] idx);
    return tt[idx];
  endfunction

  for (genvar g = 0; g < INPUTS; g++) begin : g_mask
    assign idx_o[g] = raw_i[g] & en_i[g];
  end

  assign lut_o = table_pick(tt_i, idx_o);

endmodule

// File: rtl/lut_cell_stage.sv
module lut_cell_stage
  import lut_cell_pkg::*;
#(
  parameter int SYNC_DEPTH = 2,
  parameter int HIST_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lut_i,
  input  logic [1:0] mode_i,
  output logic       stage_o,
  output logic       agree_o
);

  logic [SYNC_DEPTH-1:0] sync_q;
  logic [HIST_DEPTH-1:0] hist_q;
  logic                  hold_q;
  logic                  sync_val;
  logic                  hist_val;
  logic                  filt_val;
  logic [1:0]            warm_q;

  assign sync_val = sync_q[SYNC_DEPTH-1];
  assign hist_val = hist_q[HIST_DEPTH-1];
  assign agree_o  = (sync_val == hist_val);
  assign filt_val = agree_o ? hist_val : hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      hist_q <= '0;
      hold_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_DEPTH-2:0], lut_i};
      hist_q <= {hist_q[HIST_DEPTH-2:0], sync_val};
      hold_q <= filt_val;
    end
  end

  always_comb begin
    unique case (mode_i)
      STG_SYNC:   stage_o = sync_val;
      STG_FILTER: stage_o = filt_val;
      default:    stage_o = lut_i;
    endcase
  end

  // cycles since reset, saturating; qualifies the delay check
  always_ff @(posedge clk) begin
    if (rst)                 warm_q <= 2'd0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  assert_sync_delay_R4: assert property (@(posedge clk) disable iff (rst)
    (warm_q >= 2'd2) |-> (sync_val == $past(lut_i, 2)));

  assert_filter_gate_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_val) |-> agree_o);

endmodule

// File: rtl/lut_cell_edge.sv
module lut_cell_edge (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  input  logic edge_en_i,
  input  logic clocked_i,
  output logic pulse_o,
  output logic out_o
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level_i;
  end

  assign pulse_o = level_i & ~prev_q;

  always_comb begin
    if (!edge_en_i)     out_o = level_i;
    else if (clocked_i) out_o = pulse_o;
    else                out_o = 1'b0;
  end

  assert_edge_single_R7: assert property (@(posedge clk) disable iff (rst)
    (edge_en_i && clocked_i && out_o) |=> !pulse_o);

  assert_edge_cfg_err_R8: assert property (@(posedge clk) disable iff (rst)
    (edge_en_i && !clocked_i) |-> !out_o);

endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
#(
  parameter int INPUTS     = 3,
  parameter int SYNC_DEPTH = 2,
  parameter int HIST_DEPTH = 2,
  localparam int TT_W = 1 << INPUTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INPUTS-1:0] in_raw,
  input  logic [INPUTS-1:0] in_en,
  input  logic [TT_W-1:0]   truth_tbl,
  input  logic [1:0]        stage_mode,
  input  logic              edge_en,
  output logic              cell_out
);

  logic [INPUTS-1:0] lut_idx;
  logic              lut_val;
  logic              stage_val;
  logic              stage_agree;
  logic              stage_clocked;
  logic              edge_pulse;

  lut_cell_lut #(.INPUTS(INPUTS)) u_lut (
    .raw_i (in_raw),
    .en_i  (in_en),
    .tt_i  (truth_tbl),
    .idx_o (lut_idx),
    .lut_o (lut_val)
  );

  lut_cell_stage #(.SYNC_DEPTH(SYNC_DEPTH), .HIST_DEPTH(HIST_DEPTH)) u_stage (
    .clk     (clk),
    .rst     (rst),
    .lut_i   (lut_val),
    .mode_i  (stage_mode),
    .stage_o (stage_val),
    .agree_o (stage_agree)
  );

  assign stage_clocked = mode_is_clocked(stage_mode);

  lut_cell_edge u_edge (
    .clk       (clk),
    .rst       (rst),
    .level_i   (stage_val),
    .edge_en_i (edge_en),
    .clocked_i (stage_clocked),
    .pulse_o   (edge_pulse),
    .out_o     (cell_out)
  );

  assert_bypass_follow_R1: assert property (@(posedge clk) disable iff (rst)
    (!edge_en && !stage_clocked) |-> (cell_out == truth_tbl[lut_idx]));

  assert_mask_zero_R2: assert property (@(posedge clk) disable iff (rst)
    ((lut_idx & ~in_en) == '0));

endmodule

// File: tb/lut_cell_tb.sv
`timescale 1ns/1ps
module lut_cell_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] in_raw = '0;
  logic [2:0] in_en = 3'b111;
  logic [7:0] truth_tbl = 8'h00;
  logic [1:0] stage_mode = 2'b00;
  logic       edge_en = 1'b0;
  logic       cell_out;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  lut_cell u_dut (
    .clk(clk), .rst(rst), .in_raw(in_raw), .in_en(in_en),
    .truth_tbl(truth_tbl), .stage_mode(stage_mode), .edge_en(edge_en),
    .cell_out(cell_out)
  );

  // ---------------- reference model ----------------
  logic [3:0] m_hist = '0;   // m_hist[k]: LUT value seen k+1 edges back
  logic       m_hold = 1'b0;
  logic       m_prev = 1'b0;

  function automatic logic ref_lut(input logic [7:0] tt, input logic [2:0] r,
                                   input logic [2:0] en);
    int sel = 0;
    if (en[0] && r[0]) sel += 1;
    if (en[1] && r[1]) sel += 2;
    if (en[2] && r[2]) sel += 4;
    return (tt >> sel) & 8'h01;
  endfunction

  function automatic logic ref_filt();
    return (m_hist[1] == m_hist[3]) ? m_hist[3] : m_hold;
  endfunction

  function automatic logic ref_stage();
    if (stage_mode == 2'b01) return m_hist[1];
    if (stage_mode == 2'b10) return ref_filt();
    return ref_lut(truth_tbl, in_raw, in_en);
  endfunction

  function automatic logic ref_out();
    logic clocked = (stage_mode == 2'b01) || (stage_mode == 2'b10);
    if (!edge_en) return ref_stage();
    if (!clocked) return 1'b0;
    return ref_stage() & ~m_prev;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_hist <= '0; m_hold <= 1'b0; m_prev <= 1'b0;
    end else begin
      m_hist <= {m_hist[2:0], ref_lut(truth_tbl, in_raw, in_en)};
      m_hold <= ref_filt();
      m_prev <= ref_stage();
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_errs++;
      $display("FAIL %s: cell_out=%b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input logic [2:0] r, input string tag);
    @(negedge clk);
    in_raw = r;
    #1;
    check(tag, cell_out, ref_out());
  endtask

  task automatic cfg(input logic [7:0] tt, input logic [2:0] en,
                     input logic [1:0] md, input logic ee);
    @(negedge clk);
    truth_tbl = tt; in_en = en; stage_mode = md; edge_en = ee;
  endtask

  function automatic string mode_tag(input logic [1:0] md, input logic ee);
    if (ee && (md == 2'b00 || md == 2'b11)) return "R8";
    if (ee) return "R7";
    case (md)
      2'b00: return "R1";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  // ---------------- stimulus ----------------
  initial begin
    int lat;
    int highs;
    logic [2:0] r;
    void'($urandom(32'd1234));

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // r9_: after reset, sync mode with a LUT of all ones still reads 0
    cfg(8'hFF, 3'b111, 2'b01, 1'b0);
    #1; check("R9 reset clears sync pipeline", cell_out, 1'b0);

    // R1: every index with a table that has one bit set
    cfg(8'h00, 3'b111, 2'b00, 1'b0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); truth_tbl = 8'h01 << i; in_raw = 3'(i); #1;
      check("R1 one-hot table index", cell_out, 1'b1);
      in_raw = 3'(i) ^ 3'b001; #1;
      check("R1 neighbour index reads 0", cell_out, 1'b0);
    end

    // R3: change with no clock edge in between
    @(negedge clk); truth_tbl = 8'hAA; in_raw = 3'b000; #1;
    check("R3 bypass low", cell_out, 1'b0);
    in_raw = 3'b001; #0.5;
    check("R3 bypass follows without edge", cell_out, 1'b1);

    // R2: table 0xFE is 1 for every index but 0; masked high inputs must leave idx at 0
    @(negedge clk); truth_tbl = 8'hFE; in_en = 3'b000; in_raw = 3'b111; #1;
    check("R2 all masked reads index 0", cell_out, 1'b0);
    in_en = 3'b100; in_raw = 3'b011; #1;
    check("R2 masked inputs 0/1 ignored", cell_out, 1'b0);
    in_raw = 3'b111; #1;
    check("R2 enabled input 2 counts", cell_out, 1'b1);

    // R4: step latency in sync mode (table 0xAA follows input 0)
    cfg(8'hAA, 3'b111, 2'b01, 1'b0);
    repeat (6) step(3'b000, "R4 settle");
    @(negedge clk); in_raw = 3'b001; lat = 0;
    for (int k = 0; k < 10; k++) begin
      #1; if (cell_out) break;
      @(negedge clk); lat++;
    end
    check("R4 sync latency is 2 edges", lat == 2, 1'b1);

    // R5: step latency in filter mode
    cfg(8'hAA, 3'b111, 2'b10, 1'b0);
    repeat (8) step(3'b000, "R5 settle");
    @(negedge clk); in_raw = 3'b001; lat = 0;
    for (int k = 0; k < 10; k++) begin
      #1; if (cell_out) break;
      @(negedge clk); lat++;
    end
    check("R5 filter latency is 4 edges", lat == 4, 1'b1);

    // R5: one- and two-cycle glitches are rejected
    for (int w = 1; w <= 2; w++) begin
      repeat (8) step(3'b000, "R5 settle");
      highs = 0;
      for (int k = 0; k < w; k++) step(3'b001, "R5 glitch");
      for (int k = 0; k < 8; k++) begin
        step(3'b000, "R5 glitch tail");
        if (cell_out) highs++;
      end
      check("R5 short glitch rejected", highs == 0, 1'b1);
    end

    // R7: rising edge gives one pulse one clock long; falling edge none
    cfg(8'hAA, 3'b111, 2'b01, 1'b1);
    repeat (6) step(3'b000, "R7 settle");
    highs = 0;
    for (int k = 0; k < 8; k++) begin
      step(3'b001, "R7 rise");
      if (cell_out) highs++;
    end
    check("R7 single-cycle pulse", highs == 1, 1'b1);
    highs = 0;
    for (int k = 0; k < 8; k++) begin
      step(3'b000, "R7 fall");
      if (cell_out) highs++;
    end
    check("R7 no pulse on fall", highs == 0, 1'b1);

    // R8: edge detector with bypass and reserved modes holds low
    cfg(8'hFF, 3'b111, 2'b00, 1'b1);
    #1; check("R8 edge with bypass low", cell_out, 1'b0);
    cfg(8'hFF, 3'b111, 2'b11, 1'b1);
    #1; check("R8 edge with reserved low", cell_out, 1'b0);

    // R6: reserved mode follows the LUT combinationally
    cfg(8'h96, 3'b111, 2'b11, 1'b0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); in_raw = 3'(i); #1;
      check("R6 reserved acts as bypass", cell_out, (8'h96 >> i) & 8'h01);
    end

    // random phases across every mode and edge setting
    for (int ph = 0; ph < 24; ph++) begin
      logic [1:0] md = 2'(ph % 4);
      logic ee = ((ph / 4) % 2) == 1;
      cfg(8'($urandom), 3'($urandom) | 3'b001, md, ee);
      r = 3'($urandom);
      for (int k = 0; k < 200; k++) begin
        if (($urandom % 4) == 0) r = 3'($urandom);
        step(r, mode_tag(md, ee));
      end
    end

    // R9: mid-run reset clears filter history
    cfg(8'hFF, 3'b111, 2'b10, 1'b0);
    repeat (8) step(3'b000, "R9 prime");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    check("R9 filter cleared by reset", cell_out, 1'b0);
    for (int k = 0; k < 6; k++) step(3'b000, "R9 refill");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_errs++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

endmodule